// File: doc/BRIEF.md
# Dual-Port Indirect Register Host Interface

This block is the host-side access logic of a two-sided FIFO controller. Each of the two CPU sides owns an 8-bit data path. Through that path it reaches sixteen byte-wide register slots. Normally a side first writes a slot number and then reads or writes the slot. A side can instead use direct mode, where the slot number comes from a 4-bit address lane, so one strobe selects the slot and performs the access.

The block owns most of the register contents. Each side has a control word, a set of status bytes, a vector byte, a compare byte, a pattern byte and a mask byte. A shared enable byte and a shared line-control byte serve both sides. The block also runs a cross-coupled mailbox: a byte that one side sends appears in the other side's inbox and raises that side's pending flag.

Reset handling is part of the block:
- A side whose control word has its lock bit set sees only that word.
- The second side is cut off entirely until the first side enables it.

The FIFO storage and the interrupt arbiter sit outside. They receive push and pop strobes with data, the mailbox pending flags, and a byte-count value fed back in.

Top module: `fio_regport`

## Requirements
- R1: In pointer phase a write loads the side's 4-bit slot pointer from data bits 3:0 and enters data phase. In data phase a write goes to the pointed slot and returns to pointer phase.
- R2: A read returns the pointed slot and leaves the side in pointer phase.
- R3: While control word bit 0 (lock) of a side is 1, every read of that side returns its control word, 0x01 after reset. Non-zero writes change nothing. A write of 0x00 clears the lock and sets pointer 0 and pointer phase.
- R4: While bit 0 of the shared enable byte (slot 9) is 0, second-side reads return 0xFF. Its writes are dropped and leave its phase unchanged.
- R5: Slot 7 reads the external byte count and ignores writes. Slot 12 (inbox) ignores writes.
- R6: Only the first side can write slot 9. The second side reads slot 9 as 0x00.
- R7: A write to slot 11 puts the byte in the other side's inbox (slot 12) and sets that side's pending flag, which is bit 5 of its slot 2 and its msgPend output. Reading slot 12 clears the reader's own flag. Reading slot 11 returns the other side's inbox.
- R8: A direct-mode access sets the pointer to the address lane and data phase, then performs the access. A direct write therefore stores data and ends in pointer phase.
- R9: Writing slot 0 with bit 0 set locks that side and clears its slot 1, slot 14 and slot 2. A first-side reset also locks the second side and clears slots 9 and 10. A second-side reset leaves the first side unchanged.
- R10: Bits 3:2 of the second side's slot 0 always read the first side's bits 3:2. The second side's writes to them have no effect.
- R11: When a slot-11 write from one side and a slot-12 read from the other side fall in the same cycle, the read returns the previous inbox byte and the pending flag stays set.
- R12: Read data appears in the cycle after the read strobe and holds until the next read.
- R13: A slot-15 write pulses that side's fifoPush bit with the byte on its fifoPushData lane in the strobe cycle. A slot-15 read pulses fifoPop and returns fifoRdData.
- R14: After rstN, both control words are 0x01, both read data outputs are 0x00, msgPend is 0 and the second side is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aRdStb | input | 1 | First side read strobe |
| aWrStb | input | 1 | First side write strobe |
| aDirect | input | 1 | First side direct-mode access |
| aAddr | input | 4 | First side slot address (direct mode) |
| aWrData | input | 8 | First side write data |
| aRdData | output | 8 | First side registered read data |
| bRdStb | input | 1 | Second side read strobe |
| bWrStb | input | 1 | Second side write strobe |
| bDirect | input | 1 | Second side direct-mode access |
| bAddr | input | 4 | Second side slot address (direct mode) |
| bWrData | input | 8 | Second side write data |
| bRdData | output | 8 | Second side registered read data |
| byteCount | input | 8 | FIFO occupancy shown in slot 7 |
| fifoRdData | input | 8 | FIFO head byte returned by slot 15 |
| fifoPush | output | 2 | Push strobe per side (bit 0 first side) |
| fifoPop | output | 2 | Pop strobe per side |
| fifoPushData | output | 16 | Push byte per side (7:0 first, 15:8 second) |
| msgPend | output | 2 | Mailbox pending flag per side |

## Verification
Two functions can land in the same cycle. A mailbox deposit from the first side can coincide with the second side's inbox read, which both loads the inbox and clears the flag. A first-side reset can also coincide with second-side activity. The bench creates the first case by raising the first side's write strobe, with its pointer already on slot 11, in the same cycle as a direct read of slot 12 on the second side. It judges the result by checking three things: the read returned the old inbox byte, msgPend bit 1 is still set afterwards, and a following inbox read returns the new byte and drops the flag.

// File: rtl/fio_regport_pkg.sv
package fio_regport_pkg;
  localparam int DW       = 8;
  localparam int AW       = 4;
  localparam int NPORT    = 2;
  localparam int NSTAT    = 4;
  localparam int STAT_IW  = $clog2(NSTAT);
  localparam int PEND_BIT = 5;

  localparam logic [DW-1:0] RST_CTL0  = 8'h01;
  localparam logic [DW-1:0] MODE_MASK = 8'h0C;
  localparam logic [DW-1:0] CMP_MASK  = 8'h7F;
  localparam logic [DW-1:0] CTL2_MASK = 8'h03;
  localparam logic [DW-1:0] PEND_MASK = DW'(1) << PEND_BIT;

  localparam logic [AW-1:0] REG_CTL0   = 4'd0;
  localparam logic [AW-1:0] REG_CTL1   = 4'd1;
  localparam logic [AW-1:0] REG_STAT0  = 4'd2;
  localparam logic [AW-1:0] REG_STAT1  = 4'd3;
  localparam logic [AW-1:0] REG_STAT2  = 4'd4;
  localparam logic [AW-1:0] REG_STAT3  = 4'd5;
  localparam logic [AW-1:0] REG_VEC    = 4'd6;
  localparam logic [AW-1:0] REG_BCNT   = 4'd7;
  localparam logic [AW-1:0] REG_CMP    = 4'd8;
  localparam logic [AW-1:0] REG_CTL2   = 4'd9;
  localparam logic [AW-1:0] REG_CTL3   = 4'd10;
  localparam logic [AW-1:0] REG_MSGOUT = 4'd11;
  localparam logic [AW-1:0] REG_MSGIN  = 4'd12;
  localparam logic [AW-1:0] REG_PATT   = 4'd13;
  localparam logic [AW-1:0] REG_MASK   = 4'd14;
  localparam logic [AW-1:0] REG_FIFO   = 4'd15;

  typedef struct packed {
    logic          rd;       // read of slot sel
    logic          wr;       // write of data to slot sel
    logic          unlock;   // leave the locked state
    logic          blocked;  // read on a disabled side
    logic [AW-1:0] sel;
    logic [DW-1:0] data;
  } hostStb_t;
endpackage

// File: rtl/fio_regport_ctrl.sv
module fio_regport_ctrl
  import fio_regport_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic          direct,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          inReset,
  input  logic          enable,
  output hostStb_t      stb
);
  logic [AW-1:0] ptrQ;
  logic          phaseQ;   // 0: pointer phase, 1: data phase
  logic [AW-1:0] ptrEff;
  logic          phaseEff;
  logic          doRd;
  logic          doWr;

  assign ptrEff   = direct ? addr : ptrQ;
  assign phaseEff = direct | phaseQ;
  assign doRd     = rdStb & enable;
  assign doWr     = wrStb & ~rdStb & enable;

  always_comb begin
    stb         = '0;
    stb.data    = wrData;
    stb.sel     = inReset ? REG_CTL0 : ptrEff;
    stb.rd      = doRd;
    stb.blocked = rdStb & ~enable;
    stb.wr      = doWr & ~inReset & phaseEff;
    stb.unlock  = doWr & inReset & (wrData == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      phaseQ <= 1'b0;
    end else if (doWr) begin
      if (inReset) begin
        if (wrData == '0) begin
          ptrQ   <= '0;
          phaseQ <= 1'b0;
        end else if (direct) begin
          ptrQ   <= addr;
          phaseQ <= 1'b1;
        end
      end else if (!phaseEff) begin
        ptrQ   <= wrData[AW-1:0];
        phaseQ <= 1'b1;
      end else begin
        ptrQ   <= ptrEff;
        phaseQ <= 1'b0;
      end
    end else if (doRd) begin
      ptrQ   <= ptrEff;
      phaseQ <= inReset ? phaseEff : 1'b0;
    end
  end

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !rdStb && enable && !inReset && !direct && !phaseQ)
      |=> (phaseQ && ptrQ == $past(wrData[AW-1:0])))
    else $error("pointer-phase write did not load the pointer");

  // R2
  read_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && enable && !inReset) |=> !phaseQ)
    else $error("read left the side in data phase");

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !rdStb && inReset && wrData != '0 && !direct)
      |=> ($stable(ptrQ) && $stable(phaseQ)))
    else $error("locked side changed state on a non-zero write");

  // R8
  direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !rdStb && enable && direct && !inReset)
      |=> (!phaseQ && ptrQ == $past(addr)))
    else $error("direct write did not leave pointer at the address");

  // R4
  gate_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStb || wrStb) && !enable) |=> ($stable(phaseQ) && $stable(ptrQ)))
    else $error("disabled side changed its pointer state");
endmodule

// File: rtl/fio_regport_bank.sv
module fio_regport_bank
  import fio_regport_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  hostStb_t [NPORT-1:0]       stb,
  input  logic [DW-1:0]              byteCount,
  input  logic [DW-1:0]              fifoRdData,
  output logic [NPORT-1:0][DW-1:0]   rdData,
  output logic [NPORT-1:0]           inReset,
  output logic [NPORT-1:0]           portEnable,
  output logic [NPORT-1:0]           fifoPush,
  output logic [NPORT-1:0]           fifoPop,
  output logic [NPORT-1:0][DW-1:0]   pushData,
  output logic [NPORT-1:0]           msgPend
);
  logic [NPORT-1:0][DW-1:0]            ctl0, ctl1, vec, cmp, msgIn, patt, mask;
  logic [NPORT-1:0][NSTAT-1:0][DW-1:0] stat;
  logic [DW-1:0]                       ctl2, ctl3;
  logic [NPORT-1:0][DW-1:0]            muxOut;
  logic [NPORT-1:0][STAT_IW-1:0]       statIdx;
  logic [NPORT-1:0][DW-1:0]            rdDataQ;
  logic [NPORT-1:0]                    rstPort;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [DW-1:0] mux;
    logic [DW-1:0] ctl0View;

    assign statIdx[g]  = stb[g].sel[STAT_IW-1:0] + STAT_IW'(2);
    assign inReset[g]  = ctl0[g][0];
    assign msgPend[g]  = stat[g][0][PEND_BIT];
    assign fifoPush[g] = stb[g].wr && stb[g].sel == REG_FIFO;
    assign fifoPop[g]  = stb[g].rd && stb[g].sel == REG_FIFO;
    assign pushData[g] = stb[g].data;
    assign muxOut[g]   = mux;

    if (g == 0) begin : g_first
      assign ctl0View = ctl0[g];
    end else begin : g_other
      assign ctl0View = ctl0[g] | (ctl0[0] & MODE_MASK);
    end

    always_comb begin
      case (stb[g].sel)
        REG_CTL0:   mux = ctl0View;
        REG_CTL1:   mux = ctl1[g];
        REG_STAT0,
        REG_STAT1,
        REG_STAT2,
        REG_STAT3:  mux = stat[g][statIdx[g]];
        REG_VEC:    mux = vec[g];
        REG_BCNT:   mux = byteCount;
        REG_CMP:    mux = cmp[g];
        REG_CTL2:   mux = (g == 0) ? ctl2 : '0;
        REG_CTL3:   mux = ctl3;
        REG_MSGOUT: mux = msgIn[NPORT-1-g];
        REG_MSGIN:  mux = msgIn[g];
        REG_PATT:   mux = patt[g];
        REG_MASK:   mux = mask[g];
        default:    mux = fifoRdData;
      endcase
    end
  end

  assign portEnable = {ctl2[0], 1'b1};
  assign rdData     = rdDataQ;
  assign rstPort[0] = stb[0].wr && stb[0].sel == REG_CTL0 && stb[0].data[0];
  assign rstPort[1] = rstPort[0] || (stb[1].wr && stb[1].sel == REG_CTL0 && stb[1].data[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl0    <= {NPORT{RST_CTL0}};
      ctl1    <= '0;
      vec     <= '0;
      cmp     <= '0;
      msgIn   <= '0;
      patt    <= '0;
      mask    <= '0;
      stat    <= '0;
      ctl2    <= '0;
      ctl3    <= '0;
      rdDataQ <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (stb[p[0]].blocked)
          rdDataQ[p[0]] <= '1;
        else if (stb[p[0]].rd)
          rdDataQ[p[0]] <= muxOut[p[0]];

        if (stb[p[0]].unlock)
          ctl0[p[0]] <= '0;

        if (stb[p[0]].rd && stb[p[0]].sel == REG_MSGIN)
          stat[p[0]][0][PEND_BIT] <= 1'b0;

        if (stb[p[0]].wr) begin
          case (stb[p[0]].sel)
            REG_CTL0:
              if (!stb[p[0]].data[0])
                ctl0[p[0]] <= p[0] ? (stb[p[0]].data & ~MODE_MASK) : stb[p[0]].data;
            REG_CTL1: ctl1[p[0]] <= stb[p[0]].data;
            REG_STAT0: stat[p[0]][0] <= (stb[p[0]].data & ~PEND_MASK)
                                      | (stat[p[0]][0] & PEND_MASK);
            REG_STAT1,
            REG_STAT2,
            REG_STAT3: stat[p[0]][statIdx[p[0]]] <= stb[p[0]].data;
            REG_VEC:   vec[p[0]]  <= stb[p[0]].data;
            REG_CMP:   cmp[p[0]]  <= stb[p[0]].data & CMP_MASK;
            REG_CTL2:  if (!p[0]) ctl2 <= stb[p[0]].data & CTL2_MASK;
            REG_PATT:  patt[p[0]] <= stb[p[0]].data;
            REG_MASK:  mask[p[0]] <= stb[p[0]].data;
            default: ;
          endcase
        end
      end

      // shared line-control byte: the first side wins a collision
      if (stb[0].wr && stb[0].sel == REG_CTL3)
        ctl3 <= stb[0].data;
      else if (stb[1].wr && stb[1].sel == REG_CTL3)
        ctl3 <= stb[1].data;

      // mailbox deposits override a same-cycle inbox read clear
      if (stb[0].wr && stb[0].sel == REG_MSGOUT) begin
        msgIn[1]             <= stb[0].data;
        stat[1][0][PEND_BIT] <= 1'b1;
      end
      if (stb[1].wr && stb[1].sel == REG_MSGOUT) begin
        msgIn[0]             <= stb[1].data;
        stat[0][0][PEND_BIT] <= 1'b1;
      end

      if (rstPort[1]) begin
        ctl0[1]    <= RST_CTL0;
        ctl1[1]    <= '0;
        stat[1][0] <= '0;
        mask[1]    <= '0;
      end
      if (rstPort[0]) begin
        ctl0[0]    <= RST_CTL0;
        ctl1[0]    <= '0;
        stat[0][0] <= '0;
        mask[0]    <= '0;
        ctl2       <= '0;
        ctl3       <= '0;
      end
    end
  end

  // R4
  gate_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb[1].rd || stb[1].wr) |-> ctl2[0])
    else $error("second side accessed while disabled");

  // R6
  ctl2_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb[1].wr && !stb[0].wr) |=> $stable(ctl2))
    else $error("second side changed the shared enable byte");

  // R7
  mail_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb[0].wr && stb[0].sel == REG_MSGOUT)
      |=> (msgPend[1] && msgIn[1] == $past(stb[0].data)))
    else $error("mailbox deposit not seen on the other side");

  // R9
  reset_cascade_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb[0].wr && stb[0].sel == REG_CTL0 && stb[0].data[0])
      |=> (inReset[0] && inReset[1] && ctl2 == '0))
    else $error("first-side reset did not lock both sides");

  // R9
  b_reset_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb[1].wr && stb[1].sel == REG_CTL0 && stb[1].data[0] && !stb[0].wr && !stb[0].unlock)
      |=> $stable(ctl0[0]))
    else $error("second-side reset disturbed the first side");

  // R13
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoPush[0] && fifoPop[0]))
    else $error("push and pop on one side in one cycle");
endmodule

// File: rtl/fio_regport.sv
module fio_regport
  import fio_regport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        aRdStb,
  input  logic        aWrStb,
  input  logic        aDirect,
  input  logic [3:0]  aAddr,
  input  logic [7:0]  aWrData,
  output logic [7:0]  aRdData,
  input  logic        bRdStb,
  input  logic        bWrStb,
  input  logic        bDirect,
  input  logic [3:0]  bAddr,
  input  logic [7:0]  bWrData,
  output logic [7:0]  bRdData,
  input  logic [7:0]  byteCount,
  input  logic [7:0]  fifoRdData,
  output logic [1:0]  fifoPush,
  output logic [1:0]  fifoPop,
  output logic [15:0] fifoPushData,
  output logic [1:0]  msgPend
);
  logic [NPORT-1:0]          rdV, wrV, dirV, inResetV, enableV;
  logic [NPORT-1:0][AW-1:0]  addrV;
  logic [NPORT-1:0][DW-1:0]  dataV, rdDataV, pushDataV;
  hostStb_t [NPORT-1:0]      stbV;

  assign rdV   = {bRdStb, aRdStb};
  assign wrV   = {bWrStb, aWrStb};
  assign dirV  = {bDirect, aDirect};
  assign addrV = {bAddr, aAddr};
  assign dataV = {bWrData, aWrData};

  for (genvar g = 0; g < NPORT; g++) begin : g_ctrl
    fio_regport_ctrl ctrl_i (
      .clk     (clk),
      .rstN    (rstN),
      .rdStb   (rdV[g]),
      .wrStb   (wrV[g]),
      .direct  (dirV[g]),
      .addr    (addrV[g]),
      .wrData  (dataV[g]),
      .inReset (inResetV[g]),
      .enable  (enableV[g]),
      .stb     (stbV[g])
    );
  end

  fio_regport_bank bank_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stbV),
    .byteCount  (byteCount),
    .fifoRdData (fifoRdData),
    .rdData     (rdDataV),
    .inReset    (inResetV),
    .portEnable (enableV),
    .fifoPush   (fifoPush),
    .fifoPop    (fifoPop),
    .pushData   (pushDataV),
    .msgPend    (msgPend)
  );

  assign aRdData      = rdDataV[0];
  assign bRdData      = rdDataV[1];
  assign fifoPushData = pushDataV;
endmodule

// File: tb/fio_regport_tb_top.sv
`timescale 1ns/1ps
module fio_regport_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aRdStb = 0, aWrStb = 0, aDirect = 0;
  logic [3:0]  aAddr = 0;
  logic [7:0]  aWrData = 0;
  logic [7:0]  aRdData;
  logic        bRdStb = 0, bWrStb = 0, bDirect = 0;
  logic [3:0]  bAddr = 0;
  logic [7:0]  bWrData = 0;
  logic [7:0]  bRdData;
  logic [7:0]  byteCount = 8'h2A;
  logic [7:0]  fifoRdData = 8'h5C;
  logic [1:0]  fifoPush, fifoPop, msgPend;
  logic [15:0] fifoPushData;

  int errors = 0;
  int checks = 0;
  logic [7:0] rdv;
  logic       pushSeen, popSeen;
  logic [7:0] pushSeenData;
  logic [31:0] row;

  always #4 clk = ~clk;

  fio_regport dut_i (
    .clk(clk), .rstN(rstN),
    .aRdStb(aRdStb), .aWrStb(aWrStb), .aDirect(aDirect), .aAddr(aAddr),
    .aWrData(aWrData), .aRdData(aRdData),
    .bRdStb(bRdStb), .bWrStb(bWrStb), .bDirect(bDirect), .bAddr(bAddr),
    .bWrData(bWrData), .bRdData(bRdData),
    .byteCount(byteCount), .fifoRdData(fifoRdData),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoPushData(fifoPushData),
    .msgPend(msgPend)
  );

  localparam logic [1:0] WR = 2'd0, RD = 2'd1, DWR = 2'd2, DRD = 2'd3;
  localparam logic PA = 1'b0, PB = 1'b1, NC = 1'b0, CK = 1'b1;
  localparam int NVEC = 64;
  // row: op[31:30] side[29] check[28] addr[27:24] data[23:16] expect[15:8] req[7:0]
  localparam logic [31:0] VEC_TAB [NVEC] = '{
    {WR, PA, NC, 4'h0, 8'h09, 8'h00, 8'd4},   // enable second side
    {WR, PA, NC, 4'h0, 8'h01, 8'h00, 8'd4},
    {WR, PB, NC, 4'h0, 8'h00, 8'h00, 8'd3},   // unlock second side
    {WR, PA, NC, 4'h0, 8'h0D, 8'h00, 8'd1},   // R1
    {WR, PA, NC, 4'h0, 8'h3C, 8'h00, 8'd1},
    {WR, PA, NC, 4'h0, 8'h0D, 8'h00, 8'd1},
    {RD, PA, CK, 4'h0, 8'h00, 8'h3C, 8'd1},
    {WR, PA, NC, 4'h0, 8'h0E, 8'h00, 8'd2},   // R2
    {RD, PA, CK, 4'h0, 8'h00, 8'h00, 8'd2},
    {WR, PA, NC, 4'h0, 8'h0D, 8'h00, 8'd2},
    {WR, PA, NC, 4'h0, 8'h77, 8'h00, 8'd2},
    {WR, PA, NC, 4'h0, 8'h0D, 8'h00, 8'd2},
    {RD, PA, CK, 4'h0, 8'h00, 8'h77, 8'd2},
    {WR, PA, NC, 4'h0, 8'h07, 8'h00, 8'd5},   // R5
    {WR, PA, NC, 4'h0, 8'h99, 8'h00, 8'd5},
    {WR, PA, NC, 4'h0, 8'h07, 8'h00, 8'd5},
    {RD, PA, CK, 4'h0, 8'h00, 8'h2A, 8'd5},
    {WR, PA, NC, 4'h0, 8'h0C, 8'h00, 8'd5},
    {WR, PA, NC, 4'h0, 8'h55, 8'h00, 8'd5},
    {WR, PA, NC, 4'h0, 8'h0C, 8'h00, 8'd5},
    {RD, PA, CK, 4'h0, 8'h00, 8'h00, 8'd5},
    {WR, PB, NC, 4'h0, 8'h09, 8'h00, 8'd6},   // R6
    {WR, PB, NC, 4'h0, 8'h00, 8'h00, 8'd6},
    {WR, PA, NC, 4'h0, 8'h09, 8'h00, 8'd6},
    {RD, PA, CK, 4'h0, 8'h00, 8'h01, 8'd6},
    {WR, PB, NC, 4'h0, 8'h09, 8'h00, 8'd6},
    {RD, PB, CK, 4'h0, 8'h00, 8'h00, 8'd6},
    {WR, PA, NC, 4'h0, 8'h0B, 8'h00, 8'd7},   // R7
    {WR, PA, NC, 4'h0, 8'hA5, 8'h00, 8'd7},
    {WR, PB, NC, 4'h0, 8'h02, 8'h00, 8'd7},
    {RD, PB, CK, 4'h0, 8'h00, 8'h20, 8'd7},
    {WR, PB, NC, 4'h0, 8'h0B, 8'h00, 8'd7},
    {RD, PB, CK, 4'h0, 8'h00, 8'h00, 8'd7},
    {WR, PA, NC, 4'h0, 8'h0B, 8'h00, 8'd7},
    {RD, PA, CK, 4'h0, 8'h00, 8'hA5, 8'd7},
    {WR, PB, NC, 4'h0, 8'h0C, 8'h00, 8'd7},
    {RD, PB, CK, 4'h0, 8'h00, 8'hA5, 8'd7},
    {WR, PB, NC, 4'h0, 8'h02, 8'h00, 8'd7},
    {RD, PB, CK, 4'h0, 8'h00, 8'h00, 8'd7},
    {DWR, PA, NC, 4'h8, 8'hFF, 8'h00, 8'd8},  // R8
    {DRD, PA, CK, 4'h8, 8'h00, 8'h7F, 8'd8},
    {WR, PA, NC, 4'h0, 8'h0D, 8'h00, 8'd8},
    {RD, PA, CK, 4'h0, 8'h00, 8'h77, 8'd8},
    {DRD, PB, CK, 4'hD, 8'h00, 8'h00, 8'd8},
    {WR, PA, NC, 4'h0, 8'h00, 8'h00, 8'd10},  // R10
    {WR, PA, NC, 4'h0, 8'h0C, 8'h00, 8'd10},
    {WR, PA, NC, 4'h0, 8'h00, 8'h00, 8'd10},
    {RD, PA, CK, 4'h0, 8'h00, 8'h0C, 8'd10},
    {WR, PB, NC, 4'h0, 8'h00, 8'h00, 8'd10},
    {WR, PB, NC, 4'h0, 8'h04, 8'h00, 8'd10},
    {WR, PB, NC, 4'h0, 8'h00, 8'h00, 8'd10},
    {RD, PB, CK, 4'h0, 8'h00, 8'h0C, 8'd10},
    {WR, PA, NC, 4'h0, 8'h00, 8'h00, 8'd10},
    {WR, PA, NC, 4'h0, 8'h00, 8'h00, 8'd10},
    {DRD, PB, CK, 4'h0, 8'h00, 8'h00, 8'd10},
    {WR, PA, NC, 4'h0, 8'h09, 8'h00, 8'd4},   // R4
    {WR, PA, NC, 4'h0, 8'h00, 8'h00, 8'd4},
    {RD, PB, CK, 4'h0, 8'h00, 8'hFF, 8'd4},
    {WR, PB, NC, 4'h0, 8'h0D, 8'h00, 8'd4},
    {WR, PB, NC, 4'h0, 8'h11, 8'h00, 8'd4},
    {WR, PA, NC, 4'h0, 8'h09, 8'h00, 8'd4},
    {WR, PA, NC, 4'h0, 8'h01, 8'h00, 8'd4},
    {WR, PB, NC, 4'h0, 8'h0D, 8'h00, 8'd4},
    {RD, PB, CK, 4'h0, 8'h00, 8'h00, 8'd4}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic side, input logic [1:0] op,
                        input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    if (side == PA) begin
      aRdStb = op[0]; aWrStb = ~op[0]; aDirect = op[1]; aAddr = addr; aWrData = data;
    end else begin
      bRdStb = op[0]; bWrStb = ~op[0]; bDirect = op[1]; bAddr = addr; bWrData = data;
    end
    #1;
    pushSeen     = fifoPush[side];
    popSeen      = fifoPop[side];
    pushSeenData = side ? fifoPushData[15:8] : fifoPushData[7:0];
    @(negedge clk);
    aRdStb = 0; aWrStb = 0; aDirect = 0;
    bRdStb = 0; bWrStb = 0; bDirect = 0;
    rdv = side ? bRdData : aRdData;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R14 power-up state
    check(14, {aRdData, bRdData}, 16'h0000);
    check(14, {14'd0, msgPend}, 16'h0000);
    access(PA, RD, 4'h0, 8'h00);
    check(14, {8'h00, rdv}, 16'h0001);
    access(PB, RD, 4'h0, 8'h00);       // R4: disabled at power-up
    check(4, {8'h00, rdv}, 16'h00FF);

    // R3 lock: non-zero writes ignored, 0x00 unlocks to pointer 0 / pointer phase
    access(PA, WR, 4'h0, 8'h0D);
    access(PA, WR, 4'h0, 8'h42);
    access(PA, RD, 4'h0, 8'h00);
    check(3, {8'h00, rdv}, 16'h0001);
    access(PA, WR, 4'h0, 8'h00);
    access(PA, RD, 4'h0, 8'h00);
    check(3, {8'h00, rdv}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      row = VEC_TAB[i];
      access(row[29], row[31:30], row[27:24], row[23:16]);
      if (row[28]) check(int'(row[7:0]), {8'h00, rdv}, {8'h00, row[15:8]});
    end

    // R7 deposit then R11 same-cycle deposit and inbox read
    access(PA, WR, 4'h0, 8'h0B);
    access(PA, WR, 4'h0, 8'h3E);
    check(7, {14'd0, msgPend}, 16'h0002);
    access(PA, WR, 4'h0, 8'h0B);
    @(negedge clk);
    aWrStb = 1; aWrData = 8'h5A;
    bRdStb = 1; bDirect = 1; bAddr = 4'hC;
    @(negedge clk);
    aWrStb = 0; bRdStb = 0; bDirect = 0;
    check(11, {8'h00, bRdData}, 16'h003E);
    check(11, {15'd0, msgPend[1]}, 16'h0001);
    access(PB, DRD, 4'hC, 8'h00);
    check(11, {8'h00, rdv}, 16'h005A);
    check(7, {15'd0, msgPend[1]}, 16'h0000);

    // R13 FIFO slot strobes
    access(PA, WR, 4'h0, 8'h0F);
    access(PA, WR, 4'h0, 8'h6B);
    check(13, {7'd0, pushSeen, pushSeenData}, 16'h016B);
    access(PA, DRD, 4'hF, 8'h00);
    check(13, {7'd0, popSeen, rdv}, 16'h015C);

    // R12 read data holds between reads
    repeat (3) @(negedge clk);
    check(12, {8'h00, aRdData}, 16'h005C);

    // R9 resets
    access(PB, WR, 4'h0, 8'h0D);
    access(PB, WR, 4'h0, 8'h11);
    access(PA, WR, 4'h0, 8'h0E);
    access(PA, WR, 4'h0, 8'h33);
    access(PB, WR, 4'h0, 8'h00);
    access(PB, WR, 4'h0, 8'h01);
    access(PB, RD, 4'h0, 8'h00);
    check(9, {8'h00, rdv}, 16'h0001);
    access(PA, DRD, 4'hE, 8'h00);
    check(9, {8'h00, rdv}, 16'h0033);
    access(PB, WR, 4'h0, 8'h00);
    access(PB, DRD, 4'hD, 8'h00);
    check(9, {8'h00, rdv}, 16'h0011);
    access(PA, WR, 4'h0, 8'h00);
    access(PA, WR, 4'h0, 8'h01);
    access(PA, RD, 4'h0, 8'h00);
    check(9, {8'h00, rdv}, 16'h0001);
    access(PA, WR, 4'h0, 8'h00);
    access(PA, WR, 4'h0, 8'h09);
    access(PA, WR, 4'h0, 8'h01);
    access(PB, RD, 4'h0, 8'h00);
    check(9, {8'h00, rdv}, 16'h0001);
    access(PA, DRD, 4'hE, 8'h00);
    check(9, {8'h00, rdv}, 16'h0000);

    finish_run();
  end
endmodule